// File: doc/BRIEF.md
# Conversion Sequencer for a Single-Channel Data Converter

This block decides when a data converter runs and holds the two registers that sit behind the serial bus port: an 8-bit control/status register and a 16-bit result register. A bus front end hands it one-byte control writes and reads back the status byte and result word. The converter core itself is external. It receives a one-cycle start pulse, a power-enable level and a 2-bit gain code, and it answers with a one-cycle done pulse that carries a 12-bit two's-complement result.

Two operating modes exist. In free-running mode every finished conversion is stored and the next one is launched at once. In one-shot mode a conversion runs only when the start bit is written, and the converter is powered down once its result has been stored. A synchronous reset request returns the block to its power-on state and cancels any conversion that is running.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the control byte reads 80h: bit 7 (busy) = 1, bit 4 (one-shot select) = 0, bits 1:0 (gain) = 00. Bits 6, 5, 3 and 2 always read 0, whatever value was written to them.
- R2: The gain code (bits 1:0; 00/01/10/11 select gain 1/2/4/8) is presented on `conv_gain` in the cycle that `conv_start` is high. It stays unchanged until the next start, even if the control byte is rewritten in the meantime.
- R3: In free-running mode (bit 4 = 0), every accepted done pulse stores its result and raises `conv_start` in the very next cycle. Busy (bit 7) reads 1 at all times in this mode.
- R4: In free-running mode the value written to bit 7 has no effect: writing 0 there neither stops conversions nor clears busy.
- R5: In one-shot mode with no conversion running, a write with bit 4 = 1 and bit 7 = 1 raises `conv_start` and `conv_pwr_en` in the next cycle. The same write with bit 7 = 0 starts nothing.
- R6: In one-shot mode, a write with bit 7 = 1 while a conversion is running produces no extra start and does not change `conv_gain`.
- R7: In one-shot mode busy reads 1 while a conversion runs. In the cycle after the result is stored, busy reads 0 and `conv_pwr_en` is 0.
- R8: A write that switches from free-running to one-shot while a conversion runs lets that conversion finish and be stored. Busy then clears, power drops, and no further start is issued.
- R9: The result register holds the 12-bit code right-justified, with bits 15:12 equal to bit 11 (7FFh reads 07FFh, 800h reads F800h). It reads 0000h after reset until the first result is stored.
- R10: One cycle after `soft_rst_req`, the result reads 0000h, the control byte reads 80h and `conv_pwr_en` is 0. The aborted conversion is never stored.
- R11: After `rst` is released, `conv_start` is high in the cycle that follows the first clock edge with `rst` low.
- R12: A done pulse that arrives while no conversion is running leaves the result register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_req | input | 1 | One-cycle reset request from the bus front end |
| cfg_wr_en | input | 1 | Strobe for a control byte write |
| cfg_wr_data | input | 8 | Control byte being written |
| cfg_rd_data | output | 8 | Control/status byte for reads |
| out_data | output | 16 | Sign-extended result register |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_pwr_en | output | 1 | Converter power enable, high while a conversion runs |
| conv_gain | output | 2 | Gain code latched at conversion start |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_result | input | 12 | Two's-complement result, valid with `conv_done` |

## Verification
A wrong phase flag appears at the ports within one cycle. A sequencer that believes it is idle while the converter runs shows busy at 0 in one-shot mode and drops `conv_pwr_en`. The opposite fault shows up as a missing `conv_start` in free-running mode, or as a missing power-down after a stored result. A wrong gain latch shows on `conv_gain` only at the next start, or when the control byte is rewritten during a conversion. That is why the bench rewrites the byte during a conversion and compares `conv_gain`, the status byte and the result word against a behavioural model on every clock.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  localparam int CFG_W    = 8;
  localparam int ST_BIT   = 7;
  localparam int SC_BIT   = 4;
  localparam int GAIN_W   = 2;
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h80;

  typedef enum logic {PH_IDLE, PH_CONV} phase_e;

  typedef struct packed {
    logic              single;
    logic [GAIN_W-1:0] gain;
  } mode_t;
endpackage

// File: rtl/convseq_cfg.sv
module convseq_cfg
  import convseq_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_single,
  input  logic [GAIN_W-1:0] wr_gain,
  output mode_t             cur,
  output mode_t             nxt
);
  always_comb begin
    nxt = cur;
    if (wr_en) begin
      nxt.single = wr_single;
      nxt.gain   = wr_gain;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cur.single <= 1'b0;
      cur.gain   <= '0;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
  import convseq_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  mode_t             nxt,
  input  logic              wr_go,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              pwr_en,
  output logic [GAIN_W-1:0] gain_lat,
  output logic              capture
);
  phase_e phase_q;
  logic   launch;

  assign capture = conv_done && (phase_q == PH_CONV);

  // Idle: free-running mode launches on its own, one-shot mode needs a go write.
  // Running: only a stored result in free-running mode relaunches.
  always_comb begin
    if (phase_q == PH_IDLE) launch = !nxt.single || wr_go;
    else                    launch = capture && !nxt.single;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q    <= PH_IDLE;
      conv_start <= 1'b0;
      gain_lat   <= '0;
    end else begin
      conv_start <= launch;
      if (launch) begin
        phase_q  <= PH_CONV;
        gain_lat <= nxt.gain;
      end else if (capture) begin
        phase_q  <= PH_IDLE;
      end
    end
  end

  assign pwr_en = (phase_q == PH_CONV);
endmodule

// File: rtl/convseq_result.sv
module convseq_result #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             capture,
  input  logic [RES_W-1:0] result,
  output logic [OUT_W-1:0] out_q
);
  localparam int EXT_W = OUT_W - RES_W;

  logic [OUT_W-1:0] widened;

  generate
    if (EXT_W > 0) begin : g_ext
      assign widened = {{EXT_W{result[RES_W-1]}}, result};
    end else begin : g_flat
      assign widened = result[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr)          out_q <= '0;
    else if (capture) out_q <= widened;
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import convseq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_req,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  output logic [OUT_W-1:0]  out_data,
  output logic              conv_start,
  output logic              conv_pwr_en,
  output logic [GAIN_W-1:0] conv_gain,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  logic  clr;
  logic  capture;
  logic  busy;
  logic  unused_rsvd;
  mode_t cur;
  mode_t nxt;

  assign clr         = rst || soft_rst_req;
  assign unused_rsvd = ^{cfg_wr_data[6:5], cfg_wr_data[3:2]};

  convseq_cfg u_cfg (
    .clk       (clk),
    .clr       (clr),
    .wr_en     (cfg_wr_en),
    .wr_single (cfg_wr_data[SC_BIT]),
    .wr_gain   (cfg_wr_data[GAIN_W-1:0]),
    .cur       (cur),
    .nxt       (nxt)
  );

  convseq_ctrl u_ctrl (
    .clk        (clk),
    .clr        (clr),
    .nxt        (nxt),
    .wr_go      (cfg_wr_en && cfg_wr_data[ST_BIT]),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .pwr_en     (conv_pwr_en),
    .gain_lat   (conv_gain),
    .capture    (capture)
  );

  convseq_result #(.RES_W(RES_W), .OUT_W(OUT_W)) u_res (
    .clk     (clk),
    .clr     (clr),
    .capture (capture),
    .result  (conv_result),
    .out_q   (out_data)
  );

  assign busy        = !cur.single || conv_pwr_en;
  assign cfg_rd_data = {busy, 2'b00, cur.single, 2'b00, cur.gain};

  // R2: gain handed to the converter does not move during a conversion
  a_r2_gain_hold: assert property (@(posedge clk) disable iff (rst)
    (conv_pwr_en && !conv_start) |-> $stable(conv_gain));

  // R3: a stored result in free-running mode relaunches at once
  a_r3_relaunch: assert property (@(posedge clk) disable iff (rst)
    (capture && !nxt.single && !soft_rst_req) |=> conv_start);

  // R8: a stored result in one-shot mode parks the converter
  a_r8_park: assert property (@(posedge clk) disable iff (rst)
    (capture && nxt.single && !soft_rst_req) |=> (!conv_pwr_en && !conv_start));

  // R5: a start pulse always comes with power
  a_r5_start_powered: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_pwr_en);

  // R9: upper bits copy the result sign
  a_r9_sign_ext: assert property (@(posedge clk) disable iff (rst)
    out_data[OUT_W-1:RES_W] == {(OUT_W-RES_W){out_data[RES_W-1]}});

  // R10: reset request restores the power-on view
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |=> (out_data == '0 && cfg_rd_data == CFG_DEFAULT && !conv_pwr_en));

  // R12: a done pulse with no conversion running is dropped
  a_r12_stray_done: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !conv_pwr_en && !soft_rst_req) |=> $stable(out_data));
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst_req = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_data = 8'h00;
  logic [7:0]  cfg_rd_data;
  logic [15:0] out_data;
  logic        conv_start;
  logic        conv_pwr_en;
  logic [1:0]  conv_gain;
  logic        conv_done;
  logic [11:0] conv_result;

  logic        model_done = 1'b0;
  logic [11:0] model_val = 12'h000;
  logic        stray_done = 1'b0;
  logic [11:0] stray_val = 12'h000;

  assign conv_done   = model_done | stray_done;
  assign conv_result = stray_done ? stray_val : model_val;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit seen_edge = 0;

  conv_sequencer uut (
    .clk(clk), .rst(rst), .soft_rst_req(soft_rst_req),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .out_data(out_data), .conv_start(conv_start), .conv_pwr_en(conv_pwr_en),
    .conv_gain(conv_gain), .conv_done(conv_done), .conv_result(conv_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Converter stand-in: fixed latency, cancelled when power disappears.
  int conv_cnt = 0;
  int conv_idx = 0;
  function automatic logic [11:0] pick(int k);
    if (k == 0) return 12'h7FF;
    if (k == 1) return 12'h800;
    return 12'((k * 1237 + 311) % 4096);
  endfunction

  always @(negedge clk) begin
    model_done <= 1'b0;
    if (!conv_pwr_en)    conv_cnt = 0;
    else if (conv_start) conv_cnt = LAT;
    else if (conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 1) begin
        model_done <= 1'b1;
        model_val  <= pick(conv_idx);
        conv_idx++;
      end
    end
  end

  // Behavioural reference of the register and sequencing rules.
  int m_single = 0, m_gain = 0, m_run = 0, m_out = 0, m_start = 0, m_glat = 0;
  always @(posedge clk) begin
    int ns, ng, go, code;
    seen_edge = 1;
    if (rst || soft_rst_req) begin
      m_single = 0; m_gain = 0; m_run = 0; m_out = 0; m_start = 0; m_glat = 0;
    end else begin
      ns = cfg_wr_en ? int'(cfg_wr_data[4]) : m_single;
      ng = cfg_wr_en ? int'(cfg_wr_data[1:0]) : m_gain;
      go = 0;
      if (m_run != 0) begin
        if (conv_done) begin
          code = int'(conv_result);
          if (code >= 2048) code = code - 4096;
          m_out = code & 16'hFFFF;
          if (ns != 0) m_run = 0; else go = 1;
        end
      end else if (ns == 0) go = 1;
      else if (cfg_wr_en && cfg_wr_data[7]) go = 1;
      if (go != 0) begin m_run = 1; m_glat = ng; end
      m_start = go; m_single = ns; m_gain = ng;
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (seen_edge) begin
      expect_eq("R9 result word", int'(out_data), m_out);
      expect_eq("R7 status byte", int'(cfg_rd_data),
                ((m_run != 0 || m_single == 0) ? 128 : 0) + m_single * 16 + m_gain);
      expect_eq("R3 start pulse", int'(conv_start), m_start);
      expect_eq("R8 power enable", int'(conv_pwr_en), m_run);
      expect_eq("R2 latched gain", int'(conv_gain), m_glat);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 40; i++) begin
      if (conv_start) return;
      tick();
    end
    expect_eq("wait for start", 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      if (!conv_pwr_en) return;
      tick();
    end
    expect_eq("wait for idle", 1, 0);
  endtask

  initial begin
    logic [15:0] held;
    int starts;
    tick(3);
    // R1 / R9: reset view
    expect_eq("R1 reset byte", int'(cfg_rd_data), 8'h80);
    expect_eq("R9 reset result", int'(out_data), 0);
    rst = 1'b0;
    tick();
    // R11: automatic launch after reset
    expect_eq("R11 first start", int'(conv_start), 1);

    // R9: first two results, sign extension both ways
    tick();
    wait_start();
    expect_eq("R9 positive extend", int'(out_data), 16'h07FF);
    tick();
    wait_start();
    expect_eq("R9 negative extend", int'(out_data), 16'hF800);

    // R4 and R1: busy bit written 0 and reserved bits set in free-running mode
    write_cfg(8'h6F);
    expect_eq("R1 reserved bits", int'(cfg_rd_data), 8'h83);
    expect_eq("R4 busy kept", int'(cfg_rd_data[7]), 1);
    wait_start();
    expect_eq("R2 gain at start", int'(conv_gain), 3);
    tick();
    write_cfg(8'h01);
    expect_eq("R2 gain held", int'(conv_gain), 3);

    // R8: switch to one-shot during a conversion
    write_cfg(8'h10);
    expect_eq("R8 still busy", int'(cfg_rd_data[7]), 1);
    expect_eq("R8 still powered", int'(conv_pwr_en), 1);
    wait_idle();
    expect_eq("R8 parked byte", int'(cfg_rd_data), 8'h10);
    starts = 0;
    for (int i = 0; i < 12; i++) begin
      if (conv_start) starts++;
      tick();
    end
    expect_eq("R8 no relaunch", starts, 0);

    // R12: stray done while idle
    held = out_data;
    stray_val = 12'h555; stray_done = 1'b1;
    tick();
    stray_done = 1'b0;
    expect_eq("R12 result kept", int'(out_data), int'(held));

    // R5: start bit clear does nothing, set launches
    write_cfg(8'h12);
    expect_eq("R5 no launch", int'(conv_pwr_en), 0);
    write_cfg(8'h92);
    expect_eq("R5 launch", int'(conv_start), 1);
    expect_eq("R5 gain", int'(conv_gain), 2);

    // R6: second go during conversion
    write_cfg(8'h93);
    expect_eq("R6 no extra start", int'(conv_start), 0);
    expect_eq("R6 gain unchanged", int'(conv_gain), 2);
    expect_eq("R7 busy during run", int'(cfg_rd_data), 8'h93);
    wait_idle();
    expect_eq("R7 done byte", int'(cfg_rd_data), 8'h13);

    // R10: reset request mid conversion
    write_cfg(8'h91);
    tick(2);
    soft_rst_req = 1'b1;
    tick();
    soft_rst_req = 1'b0;
    expect_eq("R10 result cleared", int'(out_data), 0);
    expect_eq("R10 byte default", int'(cfg_rd_data), 8'h80);
    expect_eq("R10 power off", int'(conv_pwr_en), 0);
    tick();
    expect_eq("R10 free-running resumes", int'(conv_start), 1);

    // Back to one-shot then free-running from idle
    write_cfg(8'h10);
    wait_idle();
    write_cfg(8'h02);
    expect_eq("R3 launch from idle", int'(conv_start), 1);
    tick(30);
    finish_run();
  end
endmodule